// File: doc/BRIEF.md
# Modem Status Delta Detector

This block keeps the modem status byte of a 16550A-compatible serial port. It watches four incoming handshake lines (clear-to-send, data-set-ready, ring and carrier detect), holds their present levels in the upper half of an 8-bit status value and records in the lower half which lines have changed since the host last looked. A line-change interrupt request is raised whenever any change flag is set.

The raw lines are brought into the clock domain by a two-stage synchroniser before comparison. In loopback, the four modem control outputs of the port (data-terminal-ready, request-to-send and the two user outputs) stand in for the pins, so software can exercise the status path without external wiring. The change flag for ring differs from the others: it is raised only when ring goes from asserted to deasserted. A one-cycle host read strobe returns the status value and clears the change flags at the following clock edge, without losing a change that arrives at that same edge.

Top module: `mstat_tracker`

## Requirements
- R1: `rd_data[7:4]` holds the current line levels: bit 4 clear-to-send (`line_in[0]`), bit 5 data-set-ready (`line_in[1]`), bit 6 ring (`line_in[2]`), bit 7 carrier detect (`line_in[3]`); a 1 means asserted.
- R2: Change flags `rd_data[0]` (clear-to-send), `rd_data[1]` (data-set-ready) and `rd_data[3]` (carrier detect) are set when the line level differs from the stored level, on either edge, and stay set until a read clears them; further changes accumulate.
- R3: `rd_data[2]` is set only when the ring level goes from 1 to 0; a 0 to 1 ring transition sets no flag.
- R4: While `rd_stb` is high, `rd_data` shows the value before clearing; at the clock edge that ends the read all four change flags are cleared, except flags for changes detected at that same edge, which are set.
- R5: With `loop_en` high the levels come from `ctl_in` (bit 0 data-terminal-ready to data-set-ready, bit 1 request-to-send to clear-to-send, bit 2 user output 1 to ring, bit 3 user output 2 to carrier detect), `line_in` has no effect, and entering or leaving loopback records changes as in R2 and R3.
- R6: A change on `line_in` reaches `rd_data` after the third rising edge following it (two synchroniser stages plus the status register); a change on `ctl_in` in loopback reaches it after the first edge.
- R7: `irq` is 1 exactly when any of `rd_data[3:0]` is 1, in the same cycle.
- R8: Synchronous reset (`rst` high at a rising edge) gives `rd_data` = 8'hB0 (carrier detect, data-set-ready and clear-to-send asserted, ring clear, no flags) and `irq` = 0; a reset-level `line_in` of 4'hB then records no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 4 | Raw handshake lines {carrier, ring, data-set-ready, clear-to-send} |
| loop_en | input | 1 | Loopback select |
| ctl_in | input | 4 | Modem control outputs {user 2, user 1, request-to-send, data-terminal-ready} |
| rd_stb | input | 1 | Host read of the status value, one cycle per read |
| rd_data | output | 8 | Status value {levels, change flags} |
| irq | output | 1 | Line-change interrupt request |

## Verification
A wrong stored level shows in `rd_data[7:4]` in the cycle after the edge that stored it, and also corrupts the next change flag, since every flag is derived from the stored level. A lost or spurious flag shows in `rd_data[3:0]` and `irq` at once and persists until the next read, so it cannot hide between comparisons. A mis-timed synchroniser shows as an arrival one edge early or late against the expected third-edge arrival, and a wrong loopback map shows as a wrong level one edge after `ctl_in` changes.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

  localparam int LINE_W = 4;
  localparam int STAT_W = 2 * LINE_W;

  // Bit positions inside a line vector; the status byte layout depends on them.
  localparam int CTS_BIT = 0;
  localparam int DSR_BIT = 1;
  localparam int RI_BIT  = 2;
  localparam int DCD_BIT = 3;

  // Bit positions inside the modem control vector.
  localparam int DTR_BIT  = 0;
  localparam int RTS_BIT  = 1;
  localparam int OUT1_BIT = 2;
  localparam int OUT2_BIT = 3;

  typedef logic [LINE_W-1:0] lines_t;
  typedef logic [LINE_W-1:0] ctl_t;

  // Carrier, data-set-ready and clear-to-send asserted, ring clear.
  localparam lines_t LINES_RESET = 4'b1011;

  function automatic lines_t loop_map(input ctl_t c);
    lines_t m;
    m[CTS_BIT] = c[RTS_BIT];
    m[DSR_BIT] = c[DTR_BIT];
    m[RI_BIT]  = c[OUT1_BIT];
    m[DCD_BIT] = c[OUT2_BIT];
    return m;
  endfunction

endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/mstat_source_sel.sv
module mstat_source_sel
  import mstat_pkg::*;
(
  input  logic   loop_en,
  input  lines_t pin_lines,
  input  ctl_t   ctl,
  output lines_t src
);

  always_comb begin
    if (loop_en) src = loop_map(ctl);
    else         src = pin_lines;
  end

endmodule

// File: rtl/mstat_delta.sv
module mstat_delta
  import mstat_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  lines_t src,
  input  logic   rd_stb,
  output lines_t state_o,
  output lines_t delta_o,
  output logic   irq_o
);

  lines_t state_q, delta_q, chg, delta_d;
  logic   irq_q;

  always_comb begin
    chg = src ^ state_q;
    // Ring flag only on the trailing edge.
    chg[RI_BIT] = state_q[RI_BIT] & ~src[RI_BIT];
    delta_d = (rd_stb ? '0 : delta_q) | chg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LINES_RESET;
      delta_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= src;
      delta_q <= delta_d;
      irq_q   <= |delta_d;
    end
  end

  assign state_o = state_q;
  assign delta_o = delta_q;
  assign irq_o   = irq_q;

  a_r2_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

  a_r3_ring_rise_silent: assert property (@(posedge clk) disable iff (rst)
    (!rd_stb && !delta_q[RI_BIT] && !state_q[RI_BIT]) |=> !delta_q[RI_BIT]);

  a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> ((delta_q & ~(state_q ^ $past(state_q))) == '0));

endmodule

// File: rtl/mstat_tracker.sv
module mstat_tracker
  import mstat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] line_in,
  input  logic              loop_en,
  input  logic [LINE_W-1:0] ctl_in,
  input  logic              rd_stb,
  output logic [STAT_W-1:0] rd_data,
  output logic              irq
);

  lines_t pin_sync, src, state, delta;

  mstat_sync #(
    .WIDTH  (LINE_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(LINES_RESET)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (line_in),
    .q  (pin_sync)
  );

  mstat_source_sel u_sel (
    .loop_en  (loop_en),
    .pin_lines(pin_sync),
    .ctl      (ctl_in),
    .src      (src)
  );

  mstat_delta u_delta (
    .clk    (clk),
    .rst    (rst),
    .src    (src),
    .rd_stb (rd_stb),
    .state_o(state),
    .delta_o(delta),
    .irq_o  (irq)
  );

  assign rd_data = {state, delta};

  a_r5_loop_levels: assert property (@(posedge clk) disable iff (rst)
    loop_en |=> (rd_data[STAT_W-1:LINE_W] == loop_map($past(ctl_in))));

  a_r7_irq_matches_flags: assert property (@(posedge clk) disable iff (rst)
    irq == (|rd_data[LINE_W-1:0]));

endmodule

// File: tb/mstat_tracker_test.sv
module mstat_tracker_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] line_in = 4'hB;
  logic       loop_en = 1'b0;
  logic [3:0] ctl_in = 4'h0;
  logic       rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mstat_tracker uut (
    .clk(clk), .rst(rst), .line_in(line_in), .loop_en(loop_en),
    .ctl_in(ctl_in), .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq)
  );

  // Behavioural reference: delay queue for the pins, level and flag words.
  logic [3:0] pq[$];
  logic [3:0] mst = 4'hB;
  logic [3:0] mdl = 4'h0;

  initial pq = '{4'hB, 4'hB};

  always @(posedge clk) begin
    logic [3:0] emerg, nxt, ch;
    if (rst) begin
      pq = '{4'hB, 4'hB};
      mst = 4'hB;
      mdl = 4'h0;
    end else begin
      emerg = pq.pop_front();
      pq.push_back(line_in);
      nxt = loop_en ? {ctl_in[3], ctl_in[2], ctl_in[0], ctl_in[1]} : emerg;
      ch = nxt ^ mst;
      ch[2] = mst[2] && !nxt[2];
      mdl = (rd_stb ? 4'h0 : mdl) | ch;
      mst = nxt;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 levels vs model", {4'h0, rd_data[7:4]}, {4'h0, mst});
      chk("R2 flags vs model", {4'h0, rd_data[3:0]}, {4'h0, mdl});
      chk("R7 irq vs model", {7'h0, irq}, {7'h0, |mdl});
    end
  end

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  initial begin
    waitn(3);
    chk("R8 reset value in reset", rd_data, 8'hB0);
    rst = 1'b0;
    waitn(2);
    chk("R8 reset value after release", rd_data, 8'hB0);
    chk("R8 irq after reset", {7'h0, irq}, 8'h00);

    // clear-to-send drops: arrives at third edge
    line_in = 4'hA;
    waitn(1); chk("R6 not yet after edge 1", rd_data, 8'hB0);
    waitn(1); chk("R6 not yet after edge 2", rd_data, 8'hB0);
    waitn(1); chk("R6 R2 arrival after edge 3", rd_data, 8'hA1);
    chk("R7 irq raised", {7'h0, irq}, 8'h01);

    rd_stb = 1'b1;
    chk("R4 value shown during read", rd_data, 8'hA1);
    @(negedge clk); rd_stb = 1'b0;
    chk("R4 flags cleared", rd_data, 8'hA0);
    chk("R7 irq dropped", {7'h0, irq}, 8'h00);

    // ring rises: no flag; ring falls: flag
    line_in = 4'hE; waitn(3);
    chk("R3 ring rise no flag", rd_data, 8'hE0);
    line_in = 4'hA; waitn(3);
    chk("R3 ring fall flag", rd_data, 8'hA4);
    do_read();

    // carrier pulse accumulates
    line_in = 4'h2; waitn(3);
    chk("R2 carrier drop", rd_data, 8'h28);
    line_in = 4'hA; waitn(3);
    chk("R2 flag kept across return", rd_data, 8'hA8);
    do_read();

    // change at the clearing edge is kept
    line_in = 4'hB; waitn(3);
    chk("R2 clear-to-send rise", rd_data, 8'hB1);
    line_in = 4'h9; waitn(2);
    do_read();
    chk("R4 same-edge change kept", rd_data, 8'h92);
    do_read();
    chk("R4 cleared after second read", rd_data, 8'h90);

    // loopback
    ctl_in = 4'h0; loop_en = 1'b1; waitn(1);
    chk("R5 R6 enter loopback", rd_data, 8'h09);
    do_read();
    ctl_in = 4'h1; waitn(1); chk("R5 dtr to dsr", rd_data, 8'h22); do_read();
    ctl_in = 4'h2; waitn(1); chk("R5 rts to cts", rd_data, 8'h13); do_read();
    ctl_in = 4'h4; waitn(1); chk("R5 out1 to ring", rd_data, 8'h41); do_read();
    ctl_in = 4'h8; waitn(1); chk("R5 out2 to carrier", rd_data, 8'h8C); do_read();
    line_in = 4'h0; waitn(4); chk("R5 pins ignored low", rd_data, 8'h80);
    line_in = 4'hF; waitn(4); chk("R5 pins ignored high", rd_data, 8'h80);
    loop_en = 1'b0; waitn(1);
    chk("R5 leave loopback", rd_data, 8'hF3);
    do_read();

    // random phase, compared every cycle
    for (int i = 0; i < 600; i++) begin
      line_in = 4'($urandom);
      rd_stb = ($urandom % 4) == 0;
      if (($urandom % 16) == 0) loop_en = ~loop_en;
      ctl_in = 4'($urandom);
      waitn(1 + ($urandom % 3));
    end
    rd_stb = 1'b0;
    waitn(2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule